// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block moves bytes between a selectable configuration item and system memory without the host touching every byte. The host places a 16-byte descriptor in memory and rings a 64-bit doorbell with the descriptor's address. The engine then fetches the descriptor and may select a new item. It reads item bytes out to memory, skips over them, or loads memory bytes into the item. It finishes by writing a status word back over the descriptor's control field.

The doorbell region also returns a fixed 64-bit signature, so firmware can probe whether the engine is present. The item store itself, including its current-offset register, lives outside the block. The engine drives that store through a select pulse, an offset-advance strobe and a byte write strobe. It reads the selected item's validity, length, writability, offset and current byte back from the store.

Top module: `cfg_dma_engine`

## Requirements
- R1: A 4-byte doorbell write at offset 0 loads descriptor-address bits 63:32 and clears bits 31:0. A 4-byte write at offset 4 ORs its value into bits 31:0 and starts a transfer. An 8-byte write at offset 0 loads all 64 bits and starts a transfer. Any other size or offset has no effect.
- R2: A transfer first reads 16 descriptor bytes from ascending addresses starting at the doorbell address. These are interpreted big-endian: bytes 0..3 are the control word, bytes 4..7 the length, and bytes 8..15 the memory address.
- R3: When control bit 3 (value 0x08) is set, the engine issues one select pulse carrying control bits 31:16 as the key, before any data access. The store then restarts the item offset at zero.
- R4: The operation is chosen by priority: read (0x02) first, then write (0x10), then skip (0x04). With none of these bits set, no data access is made and the length counts as zero.
- R5: A read copies item bytes from the current offset to ascending memory addresses, one byte per access, and advances the offset by one per item byte. Bytes past the item end, and all bytes of an invalid item, are written as zero without advancing the offset.
- R6: A skip makes no memory data access. It advances the offset by the smaller of the length and the bytes left in the item.
- R7: A write with non-zero length fails, with no memory or item access, if the item is invalid, read-only, or has fewer bytes left than the length. Otherwise each memory byte is stored into the item at the current offset, which then advances by one.
- R8: At the end, 4 status bytes are written big-endian to the descriptor's first four addresses. The value is 0x00000000 on success or 0x00000001 on error.
- R9: A memory error during the descriptor fetch ends the transfer with status 0x00000001, and no select or data phase follows. A memory error during the data phase stops it at that byte, with status 0x00000001.
- R10: A doorbell read of size 1, 2, 4 or 8 bytes at offset a, with a+size no more than 8, returns bytes a..a+size-1 of the signature 0x51454D5520434647, counted from its most significant byte, right-aligned. Other read shapes return zero. Read data appears in the cycle after the read strobe.
- R11: busy rises after a starting doorbell write and falls after the last status byte is acknowledged. No memory request is made while busy is low, and doorbell writes made while busy is high are ignored.
- R12: Each memory request holds mem_req, mem_addr, mem_we and mem_wdata stable until mem_ack.
- R13: The stored doorbell address returns to zero when a transfer starts, so a later lone 4-byte write at offset 4 starts from that 32-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Doorbell write strobe |
| reg_rd | input | 1 | Doorbell read strobe |
| reg_addr | input | 3 | Byte offset within the doorbell region |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature read data, registered |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | Single-cycle completion of a request |
| mem_err | input | 1 | Request failed, valid with mem_ack |
| sel_req | output | 1 | Item select pulse |
| sel_key | output | 16 | Key for the select pulse |
| cur_valid | input | 1 | Selected item exists |
| cur_len | input | 32 | Selected item length in bytes |
| cur_writable | input | 1 | Selected item accepts writes |
| cur_offset | input | 32 | Current item offset |
| cur_rdata | input | 8 | Item byte at the current offset |
| item_we | output | 1 | Store item_wdata at the current offset |
| item_wdata | output | 8 | Item write byte |
| off_inc | output | 1 | Advance the item offset |
| off_amt | output | 32 | Offset advance amount |

## Verification
The hardest situations to reach are the ones where the item offset already sits partway into an item when a transfer begins without a select. These are the run-off-the-end zero fill, the short-item write error, and a skip clipped by the item end. A memory fault landing on one particular byte in the middle of a data phase is also hard to hit. The stimulus chains many random descriptors against a persistent item store, so offsets carry over between transfers and items are reselected only at random. A responder returns an error on one chosen address, and a few directed descriptors aim that address at a mid-transfer byte and at a descriptor byte. A long read under slow acknowledgements holds the engine busy, so a doorbell write can be placed inside the busy window.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int LEN_W      = 32;
  localparam int KEY_W      = 16;
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
  localparam int CNT_W      = $clog2(DESC_BYTES);
  localparam int DESC_W     = DESC_BYTES * 8;

  localparam logic [63:0] SIGNATURE = 64'h51454D5520434647;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_SKIP} op_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SELECT, ST_SETTLE, ST_PLAN, ST_MOVE, ST_STATUS
  } st_t;
endpackage

// File: rtl/cfg_dma_opdec.sv
module cfg_dma_opdec
  import cfg_dma_pkg::*;
(
  input  logic [3:0] ctl_bits,  // control bits 4:1
  output op_t        op,
  output logic       do_sel
);
  // ctl_bits[0]=read, [1]=skip, [2]=select, [3]=write
  always_comb begin
    do_sel = ctl_bits[2];
    if (ctl_bits[0])      op = OP_READ;
    else if (ctl_bits[3]) op = OP_WRITE;
    else if (ctl_bits[1]) op = OP_SKIP;
    else                  op = OP_NONE;
  end
endmodule

// File: rtl/cfg_dma_doorbell.sv
module cfg_dma_doorbell
  import cfg_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        busy,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        start,
  output logic [63:0] start_addr
);
  logic [63:0] ptr_q;
  logic [3:0]  end_b;
  logic        rd_ok;
  logic [6:0]  shamt;
  logic [63:0] sig_sh;
  logic [63:0] rd_val;
  logic        accept;

  assign accept = reg_wr && !busy && !start;

  always_comb begin
    end_b  = {1'b0, reg_addr} + reg_size;
    rd_ok  = (reg_size == 4'd1 || reg_size == 4'd2 || reg_size == 4'd4 ||
              reg_size == 4'd8) && (end_b <= 4'd8);
    shamt  = {(4'd8 - end_b), 3'b000};
    sig_sh = SIGNATURE >> shamt;
    rd_val = '0;
    for (int b = 0; b < 8; b++) begin
      if (4'(b) < reg_size) rd_val[b*8 +: 8] = sig_sh[b*8 +: 8];
    end
    if (!rd_ok) rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      start      <= 1'b0;
      start_addr <= '0;
      reg_rdata  <= '0;
    end else begin
      start <= 1'b0;
      if (reg_rd) reg_rdata <= rd_val;
      if (accept) begin
        if (reg_size == 4'd4 && reg_addr == 3'd0) begin
          ptr_q <= {reg_wdata[31:0], 32'h0};
        end else if (reg_size == 4'd4 && reg_addr == 3'd4) begin
          start      <= 1'b1;
          start_addr <= ptr_q | {32'h0, reg_wdata[31:0]};
          ptr_q      <= '0;
        end else if (reg_size == 4'd8 && reg_addr == 3'd0) begin
          start      <= 1'b1;
          start_addr <= reg_wdata;
          ptr_q      <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_dma_seq.sv
module cfg_dma_seq
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [63:0]       start_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              sel_req,
  output logic [KEY_W-1:0]  sel_key,
  input  logic              cur_valid,
  input  logic [LEN_W-1:0]  cur_len,
  input  logic              cur_writable,
  input  logic [LEN_W-1:0]  cur_offset,
  input  logic [7:0]        cur_rdata,
  output logic              item_we,
  output logic [7:0]        item_wdata,
  output logic              off_inc,
  output logic [LEN_W-1:0]  off_amt,
  output logic [3:0]        ctl_bits,
  input  op_t               op,
  input  logic              do_sel
);
  st_t               st;
  logic [63:0]       base;
  logic [CNT_W-1:0]  cnt;
  logic [DESC_W-1:0] desc;
  logic [LEN_W-1:0]  rem;
  logic [63:0]       ptr;
  logic              err;
  logic              gap;
  op_t               op_q;
  logic [LEN_W-1:0]  avail;
  logic [LEN_W-1:0]  skip_amt;

  assign ctl_bits = desc[DESC_W-32+4 : DESC_W-32+1];

  always_comb begin
    avail    = (cur_valid && cur_offset < cur_len) ? cur_len - cur_offset : '0;
    skip_amt = (rem < avail) ? rem : avail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; busy <= 1'b0; base <= '0; cnt <= '0; desc <= '0;
      rem <= '0; ptr <= '0; err <= 1'b0; gap <= 1'b0; op_q <= OP_NONE;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      sel_req <= 1'b0; sel_key <= '0; item_we <= 1'b0; item_wdata <= '0;
      off_inc <= 1'b0; off_amt <= '0;
    end else begin
      off_inc <= 1'b0;
      item_we <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          base <= start_addr; busy <= 1'b1; cnt <= '0; err <= 1'b0;
          st   <= ST_FETCH;
        end
        ST_FETCH: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ADDR_W'(base + 64'(cnt));
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (mem_err) begin
              err <= 1'b1; cnt <= '0; st <= ST_STATUS;
            end else begin
              desc <= {desc[DESC_W-9:0], mem_rdata};
              cnt  <= cnt + 1'b1;
              if (cnt == CNT_W'(DESC_BYTES - 1)) st <= ST_SELECT;
            end
          end
        end
        ST_SELECT: begin
          rem  <= desc[DESC_W-33 -: LEN_W];
          ptr  <= desc[63:0];
          op_q <= op;
          if (do_sel) begin
            sel_req <= 1'b1;
            sel_key <= desc[DESC_W-1 -: KEY_W];
          end
          st <= ST_SETTLE;
        end
        ST_SETTLE: begin
          sel_req <= 1'b0;
          st      <= ST_PLAN;
        end
        ST_PLAN: begin
          gap <= 1'b0;
          case (op_q)
            OP_SKIP: begin
              off_inc <= 1'b1; off_amt <= skip_amt; st <= ST_STATUS;
            end
            OP_WRITE: begin
              if (rem == '0) st <= ST_STATUS;
              else if (!cur_valid || !cur_writable || avail < rem) begin
                err <= 1'b1; st <= ST_STATUS;
              end else st <= ST_MOVE;
            end
            OP_READ: st <= ST_MOVE;
            default: st <= ST_STATUS;
          endcase
        end
        ST_MOVE: begin
          if (!mem_req) begin
            if (gap) gap <= 1'b0;
            else if (rem == '0) st <= ST_STATUS;
            else begin
              mem_req   <= 1'b1;
              mem_addr  <= ADDR_W'(ptr);
              mem_we    <= (op_q == OP_READ);
              mem_wdata <= (avail != '0) ? cur_rdata : 8'h00;
            end
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            gap     <= 1'b1;
            if (mem_err) begin
              err <= 1'b1; st <= ST_STATUS;
            end else begin
              ptr <= ptr + 64'd1;
              rem <= rem - 1'b1;
              if (op_q == OP_READ) begin
                if (avail != '0) begin off_inc <= 1'b1; off_amt <= LEN_W'(1); end
              end else begin
                item_we <= 1'b1; item_wdata <= mem_rdata;
                off_inc <= 1'b1; off_amt <= LEN_W'(1);
              end
            end
          end
        end
        ST_STATUS: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ADDR_W'(base + 64'(cnt));
            mem_wdata <= (cnt == CNT_W'(STAT_BYTES - 1)) ? {7'b0, err} : 8'h00;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            cnt     <= cnt + 1'b1;
            if (cnt == CNT_W'(STAT_BYTES - 1)) begin
              busy <= 1'b0; st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              sel_req,
  output logic [15:0]       sel_key,
  input  logic              cur_valid,
  input  logic [31:0]       cur_len,
  input  logic              cur_writable,
  input  logic [31:0]       cur_offset,
  input  logic [7:0]        cur_rdata,
  output logic              item_we,
  output logic [7:0]        item_wdata,
  output logic              off_inc,
  output logic [31:0]       off_amt
);
  logic        start;
  logic [63:0] start_addr;
  logic [3:0]  ctl_bits;
  op_t         op;
  logic        do_sel;

  cfg_dma_doorbell u_doorbell (
    .clk, .rst, .busy, .reg_wr, .reg_rd, .reg_addr, .reg_size, .reg_wdata,
    .reg_rdata, .start, .start_addr
  );

  cfg_dma_opdec u_opdec (.ctl_bits, .op, .do_sel);

  cfg_dma_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst, .start, .start_addr, .busy,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack, .mem_err,
    .sel_req, .sel_key, .cur_valid, .cur_len, .cur_writable, .cur_offset,
    .cur_rdata, .item_we, .item_wdata, .off_inc, .off_amt,
    .ctl_bits, .op, .do_sel
  );
endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [2:0]        reg_addr,
  input logic [3:0]        reg_size,
  input logic [63:0]       reg_rdata,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ack,
  input logic              sel_req,
  input logic              item_we,
  input logic              off_inc,
  input logic [31:0]       off_amt
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));

  p_no_req_idle_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_sel_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    sel_req |=> !sel_req);

  p_item_write_r7: assert property (@(posedge clk) disable iff (rst)
    item_we |-> off_inc && off_amt == 32'd1 && $past(mem_ack) && !$past(mem_we));

  p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_ack) && $past(mem_we));

  p_signature_r10: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_size == 4'd8 && reg_addr == 3'd0 |=>
      reg_rdata == 64'h51454D5520434647);
endmodule

bind cfg_dma_engine cfg_dma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk, .rst, .reg_rd, .reg_addr, .reg_size, .reg_rdata, .busy, .mem_req,
  .mem_we, .mem_addr, .mem_wdata, .mem_ack, .sel_req, .item_we, .off_inc,
  .off_amt
);

// File: tb/cfg_dma_engine_bench.sv
module cfg_dma_engine_bench;
  localparam logic [63:0] SIG = 64'h51454D5520434647;
  localparam logic [63:0] NOFAULT = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [3:0] reg_size = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic busy, mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 0;
  logic mem_ack = 0, mem_err = 0;
  logic sel_req; logic [15:0] sel_key;
  logic cur_valid, cur_writable;
  logic [31:0] cur_len, cur_offset;
  logic [7:0] cur_rdata;
  logic item_we; logic [7:0] item_wdata;
  logic off_inc; logic [31:0] off_amt;

  always #4 clk = ~clk;

  cfg_dma_engine u_cfg_dma_engine (.*);

  // item store model: keys 0..3 exist, up to 16 bytes each
  logic [7:0]  st_data [4][16];
  logic [31:0] st_len  [4];
  logic        st_wr   [4];
  logic [15:0] st_key;
  logic [31:0] st_off;
  assign cur_valid    = st_key < 16'd4;
  assign cur_len      = cur_valid ? st_len[st_key[1:0]] : 32'd0;
  assign cur_writable = cur_valid ? st_wr[st_key[1:0]] : 1'b0;
  assign cur_offset   = st_off;
  assign cur_rdata    = (cur_valid && st_off < 32'd16) ? st_data[st_key[1:0]][st_off[3:0]] : 8'h00;

  always @(posedge clk) begin
    if (rst) begin st_key <= 16'd0; st_off <= 32'd0; end
    else begin
      if (sel_req) begin st_key <= sel_key; st_off <= 32'd0; end
      else if (off_inc) st_off <= st_off + off_amt;
      if (item_we && cur_valid && st_off < 32'd16)
        st_data[st_key[1:0]][st_off[3:0]] <= item_wdata;
    end
  end

  // memory responder
  logic [7:0]  mem_arr [256];
  logic [63:0] fault_addr = NOFAULT;
  logic [63:0] first_addr = 0;
  logic        cap_arm = 0;
  int          dly = 0;
  int          slow = 0;
  always @(negedge clk) begin
    if (mem_ack) begin mem_ack = 0; mem_err = 0; end
    else if (mem_req && !rst) begin
      if (dly > 0) dly--;
      else begin
        if (cap_arm) begin first_addr = mem_addr; cap_arm = 0; end
        if (mem_addr == fault_addr) mem_err = 1;
        else if (mem_we) mem_arr[mem_addr[7:0]] = mem_wdata;
        else mem_rdata = mem_arr[mem_addr[7:0]];
        mem_ack = 1;
        dly = slow + int'($urandom % 3);
      end
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected state
  logic [7:0]  exp_mem  [256];
  logic [7:0]  exp_data [4][16];
  logic [15:0] exp_key;
  logic [31:0] exp_off;

  function automatic logic [63:0] sig_exp(input int a, input int s);
    logic [63:0] v = 0;
    if (!(s == 1 || s == 2 || s == 4 || s == 8) || a + s > 8) return 0;
    for (int i = 0; i < s; i++) v = {v[55:0], SIG[63 - 8*(a+i) -: 8]};
    return v;
  endfunction

  task automatic model(input logic [7:0] d, input logic [63:0] fa);
    logic [31:0] ctl, len, ilen, avail;
    logic [63:0] addr, a;
    logic e, valid, wr;
    logic [1:0] k;
    exp_mem = mem_arr; exp_data = st_data; exp_key = st_key; exp_off = st_off;
    ctl = 0; len = 0; addr = 0;
    for (int i = 0; i < 4; i++) ctl  = {ctl[23:0],  mem_arr[8'(d + i)]};
    for (int i = 4; i < 8; i++) len  = {len[23:0],  mem_arr[8'(d + i)]};
    for (int i = 8; i < 16; i++) addr = {addr[55:0], mem_arr[8'(d + i)]};
    e = 0;
    for (int i = 0; i < 16; i++) if (fa == 64'(d) + 64'(i)) e = 1;
    if (!e) begin
      if (ctl[3]) begin exp_key = ctl[31:16]; exp_off = 0; end
      valid = exp_key < 16'd4; k = exp_key[1:0];
      ilen  = valid ? st_len[k] : 0;
      wr    = valid ? st_wr[k] : 0;
      avail = (exp_off < ilen) ? ilen - exp_off : 0;
      if (ctl[1]) begin
        for (int i = 0; i < int'(len); i++) begin
          a = addr + 64'(i);
          if (a == fa) begin e = 1; break; end
          if (exp_off < ilen) begin exp_mem[a[7:0]] = exp_data[k][exp_off[3:0]]; exp_off++; end
          else exp_mem[a[7:0]] = 8'h00;
        end
      end else if (ctl[4]) begin
        if (len != 0) begin
          if (!valid || !wr || avail < len) e = 1;
          else for (int i = 0; i < int'(len); i++) begin
            a = addr + 64'(i);
            if (a == fa) begin e = 1; break; end
            exp_data[k][exp_off[3:0]] = exp_mem[a[7:0]]; exp_off++;
          end
        end
      end else if (ctl[2]) exp_off += (len < avail) ? len : avail;
    end
    for (int i = 0; i < 3; i++) exp_mem[8'(d + i)] = 8'h00;
    exp_mem[8'(d + 3)] = {7'b0, e};
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [3:0] s, input logic [63:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_size = s; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, input logic [3:0] s, output logic [63:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a; reg_size = s;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!busy && t < 20) begin @(negedge clk); t++; end
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    if (busy || t == 0) check(0, "R11 busy window", 64'(busy), 0);
  endtask

  task automatic put_desc(input logic [7:0] d, input logic [31:0] ctl, input logic [31:0] len, input logic [7:0] da);
    for (int i = 0; i < 4; i++) mem_arr[8'(d + i)] = ctl[31 - 8*i -: 8];
    for (int i = 0; i < 4; i++) mem_arr[8'(d + 4 + i)] = len[31 - 8*i -: 8];
    for (int i = 0; i < 7; i++) mem_arr[8'(d + 8 + i)] = 8'h00;
    mem_arr[8'(d + 15)] = da;
  endtask

  task automatic compare(input logic [7:0] d, input string tag);
    logic ok = 1;
    check(mem_arr[8'(d + 3)] == exp_mem[8'(d + 3)] && mem_arr[8'(d)] == 8'h00,
          {"R8 status ", tag}, 64'(mem_arr[8'(d + 3)]), 64'(exp_mem[8'(d + 3)]));
    for (int i = 0; i < 256; i++) if (mem_arr[i] != exp_mem[i]) begin
      ok = 0; check(0, {"R5 memory ", tag}, 64'(i), 64'(exp_mem[i])); break;
    end
    if (ok) check(1, "R5", 0, 0);
    ok = 1;
    for (int k = 0; k < 4; k++) for (int j = 0; j < 16; j++)
      if (st_data[k][j] != exp_data[k][j]) ok = 0;
    check(ok, {"R7 item bytes ", tag}, 64'(ok), 1);
    check(st_off == exp_off, {"R6 offset ", tag}, 64'(st_off), 64'(exp_off));
    check(st_key == exp_key, {"R3 key ", tag}, 64'(st_key), 64'(exp_key));
  endtask

  task automatic run(input logic [7:0] d, input logic [31:0] ctl, input logic [31:0] len,
                     input logic [7:0] da, input logic [63:0] fa, input string tag);
    put_desc(d, ctl, len, da);
    fault_addr = fa;
    model(d, fa);
    cap_arm = 1;
    reg_write(3'd0, 4'd8, 64'(d));
    wait_done();
    check(first_addr == 64'(d), {"R2 fetch base ", tag}, first_addr, 64'(d));
    compare(d, tag);
    fault_addr = NOFAULT;
  endtask

  task automatic init_items(input logic rnd);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      st_len[k] = rnd ? 32'($urandom % 17) : 32'(8 + 2*k);
      st_wr[k]  = rnd ? 1'($urandom % 2) : (k % 2 == 0);
      for (int j = 0; j < 16; j++) st_data[k][j] = 8'($urandom);
    end
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [63:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem_arr[i] = 8'($urandom);
    init_items(0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R11, R12)
    check(busy == 0, "R11 reset busy", 64'(busy), 0);
    check(mem_req == 0, "R12 reset req", 64'(mem_req), 0);
    check(reg_rdata == 0, "R10 reset rdata", reg_rdata, 0);

    // R10 signature shapes
    for (int a = 0; a < 8; a++) for (int s = 1; s <= 8; s++) begin
      reg_read(3'(a), 4'(s), v);
      check(v == sig_exp(a, s), "R10 signature", v, sig_exp(a, s));
    end

    // directed transfers, offsets carry over
    run(8'h00, 32'h0000_000A, 32'd8,  8'h40, NOFAULT, "read sel0");          // R5
    run(8'h10, 32'h0000_0002, 32'd6,  8'h50, NOFAULT, "read past end");      // R5 zero fill
    run(8'h20, 32'h0007_000A, 32'd5,  8'h60, NOFAULT, "read invalid key");   // R5
    run(8'h00, 32'h0002_0018, 32'd4,  8'h70, NOFAULT, "write ok");           // R7
    run(8'h10, 32'h0001_0018, 32'd2,  8'h78, NOFAULT, "write read-only");    // R7
    run(8'h20, 32'h0002_0018, 32'd13, 8'h80, NOFAULT, "write short");        // R7
    run(8'h00, 32'h0003_000C, 32'd40, 8'h90, NOFAULT, "skip clipped");       // R6
    run(8'h10, 32'h0000_0008, 32'd9,  8'h90, NOFAULT, "no op");              // R4
    run(8'h20, 32'h0000_001E, 32'd3,  8'h98, NOFAULT, "read beats write");   // R4
    run(8'h00, 32'h0002_0014, 32'd3,  8'hA0, NOFAULT, "write beats skip");   // R4
    run(8'h10, 32'h0001_000A, 32'd6,  8'hA8, 64'h0000_0000_0000_0018, "fetch fault");  // R9
    run(8'h20, 32'h0000_000A, 32'd8,  8'hB0, 64'h0000_0000_0000_00B3, "data fault");   // R9

    // R1 split doorbell with a rejected 2-byte write between halves
    put_desc(8'h10, 32'h0001_000A, 32'd4, 8'hC0);
    model(8'h10, NOFAULT);
    cap_arm = 1;
    reg_write(3'd0, 4'd4, 64'h0000_0000_0000_0001);
    reg_write(3'd0, 4'd2, 64'h0000_0000_0000_FFFF);
    reg_write(3'd4, 4'd4, 64'h0000_0000_0000_0010);
    wait_done();
    check(first_addr == 64'h0000_0001_0000_0010, "R1 split address", first_addr, 64'h0000_0001_0000_0010);
    compare(8'h10, "split");
    // R1 rejected shape starts nothing
    reg_write(3'd4, 4'd8, 64'h0000_0000_0000_0020);
    repeat (6) @(negedge clk);
    check(busy == 0, "R1 bad shape no start", 64'(busy), 0);
    // R13 address cleared on start: lone low half
    put_desc(8'h20, 32'h0000_000C, 32'd2, 8'hC8);
    model(8'h20, NOFAULT);
    cap_arm = 1;
    reg_write(3'd4, 4'd4, 64'h0000_0000_0000_0020);
    wait_done();
    check(first_addr == 64'h20, "R13 cleared upper", first_addr, 64'h20);
    compare(8'h20, "lone low");

    // R11 doorbell ignored while busy
    slow = 3;
    put_desc(8'h00, 32'h0000_000A, 32'd20, 8'hD0);
    put_desc(8'h10, 32'h0001_000A, 32'd4,  8'hE8);
    model(8'h00, NOFAULT);
    reg_write(3'd0, 4'd8, 64'h0);
    repeat (30) @(negedge clk);
    reg_write(3'd0, 4'd8, 64'h10);
    wait_done();
    slow = 0;
    repeat (10) @(negedge clk);
    check(busy == 0 && mem_req == 0, "R11 ignored while busy", 64'(busy), 0);
    compare(8'h00, "busy ignore");

    // random descriptors against a persistent store
    for (int n = 0; n < 60; n++) begin
      logic [7:0]  d  = 8'(16 * ($urandom % 3));
      logic [31:0] ln = 32'($urandom % 21);
      logic [7:0]  da = 8'(8'h40 + $urandom % 8'h60);
      logic [15:0] ky = 16'($urandom % 6);
      logic [31:0] ct = {ky, 11'b0, 5'($urandom)};
      logic [63:0] fa = NOFAULT;
      if (n % 10 == 9) init_items(1);
      for (int i = 8'h40; i < 256; i++) mem_arr[i] = 8'($urandom);
      if ($urandom % 6 == 0 && ln != 0) fa = 64'(da) + 64'($urandom % ln);
      run(d, ct, ln, da, fa, "random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule